// File: doc/BRIEF.md
# Two-Wire Avionics Word Serializer with Transmit Queue

This block sends 32-bit avionics data words in a bipolar return-to-zero format on two digital lines, A and B. A host writes each word as two 16-bit halves, lower half first. The second write commits the word to a 32-entry queue. While the transmit enable is high, the serializer takes the oldest queued word and sends it one bit at a time, starting with bit 1. Each bit is a driven half followed by a null half. The serializer then holds the lines null for a fixed gap before it starts the next word.

Three per-word controls are sampled when a word leaves the queue: a rate select (fast or slow timing), a parity enable, and a parity sense. A test input forces both lines to null without stopping the internal timing. A ready output reports that the queue is empty and no word or gap is in progress. The analog line driver and all receive logic lie outside this block.

Top module: `a429_tx`

## Requirements
- R1: Line encoding is A=1,B=0 for a one, A=0,B=1 for a zero, and A=0,B=0 for null. Both lines are never high together.
- R2: With `rate_low`=0, every bit drives its value for 5 clocks and then holds null for 5 clocks.
- R3: With `rate_low`=1, every bit drives its value for 40 clocks and then holds null for 40 clocks.
- R4: After the null half of bit 32, the lines stay null for a further 40 clocks (fast) or 320 clocks (slow) before any next word. Rate and parity controls are sampled when a word is taken from the queue.
- R5: With `par_en`=1, bit 32 (word bit index 31) is replaced so that the count of ones in all 32 bits is odd when `par_even`=0 and even when `par_even`=1.
- R6: With `par_en`=0, all 32 written bits are sent unchanged.
- R7: The queue holds 32 words. A commit while 32 words are held is dropped, and the queued words are left unchanged.
- R8: A word is written as two `wr_en` cycles. The first carries bits 16..1 (word indices 15..0) and the second carries bits 32..17 and commits the word. A lone first half commits nothing.
- R9: When the serializer is idle, `tx_en` is high and the queue is non-empty, the first bit drives the lines right after the clock edge that samples this. The second edge after `tx_en` is set therefore already shows it.
- R10: `tx_ready` is high exactly when the queue is empty and no word or gap is in progress. After reset, `tx_ready`=1 and both lines are null.
- R11: `test_null`=1 forces both lines null while all sequencing continues unchanged.
- R12: Bit 1 (bit 0 of the first half written) is sent first and bit 32 is sent last.
- R13: Dropping `tx_en` lets the current word and its gap finish. No further word starts until `tx_en` returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all bit timing is counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Half-word write strobe |
| wr_data | input | 16 | Half-word write data |
| tx_en | input | 1 | Allows words to leave the queue |
| rate_low | input | 1 | 0 selects fast timing, 1 selects slow timing |
| par_en | input | 1 | 1 replaces bit 32 with a generated parity bit |
| par_even | input | 1 | Parity sense: 0 odd, 1 even |
| test_null | input | 1 | Forces both lines null |
| line_a | output | 1 | Line A, high for a one |
| line_b | output | 1 | Line B, high for a zero |
| tx_ready | output | 1 | Queue empty and serializer idle |

## Verification
A bit counter that is wrong makes a word too long or too short. This shows up at the gap after that word: the null run between words has the wrong length, and `tx_ready` rises early or late. A queue pointer that is wrong makes a word repeat or go missing at the next word boundary. A half-counter fault stretches or shrinks the very first driven half. A bench model that follows the requirements predicts both lines and `tx_ready` on every clock, so any divergence is reported within one cycle of the point where it reaches the ports. A line decoder also rebuilds whole words and measures the driven and null run lengths.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_MARK  = 2'd1,
      PH_SPACE = 2'd2,
      PH_GAP   = 2'd3
   } tx_phase_t;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/a429_half_loader.sv
module a429_half_loader #(
   parameter int WORD_W = 32,
   localparam int HALF_W = WORD_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [HALF_W-1:0] wr_data,
   output logic              commit,
   output logic [WORD_W-1:0] commit_word
);

   logic              have_low;
   logic [HALF_W-1:0] low_q;

   assign commit      = wr_en && have_low;
   assign commit_word = {wr_data, low_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_low <= 1'b0;
         low_q    <= '0;
      end else if (wr_en) begin
         if (!have_low) begin
            low_q    <= wr_data;
            have_low <= 1'b1;
         end else begin
            have_low <= 1'b0;
         end
      end
   end

   // R8: a commit always returns the loader to waiting for a lower half
   p_commit_rearms_r8: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !have_low);

endmodule

// File: rtl/a429_word_fifo.sv
module a429_word_fifo #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 32,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic             empty,
   output logic             full
);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW:0]      wr_ptr, rd_ptr;
   logic             push_ok;

   assign empty   = (wr_ptr == rd_ptr);
   assign full    = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
   assign push_ok = push && !full;
   assign head    = mem[rd_ptr[AW-1:0]];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr[AW-1:0]] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop)     rd_ptr <= rd_ptr + 1'b1;
      end
   end

   // R7: a push against a full queue leaves it full and untouched
   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> (full && $stable(wr_ptr)));

   // R7: the serializer never takes a word from an empty queue
   p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

endmodule

// File: rtl/a429_bit_engine.sv
module a429_bit_engine
   import a429_tx_pkg::*;
#(
   parameter int WORD_W  = 32,
   parameter int HS_HALF = 5,
   parameter int LS_HALF = 40,
   parameter int HS_GAP  = 40,
   parameter int LS_GAP  = 320,
   localparam int MAXC = imax(imax(HS_HALF, LS_HALF), imax(HS_GAP, LS_GAP)),
   localparam int CW   = $clog2(MAXC + 1),
   localparam int BW   = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              rate_low,
   input  logic              par_en,
   input  logic              par_even,
   input  logic              q_empty,
   input  logic [WORD_W-1:0] q_head,
   output logic              q_pop,
   output logic              drive_a,
   output logic              drive_b,
   output logic              idle
);

   tx_phase_t         ph;
   logic [CW-1:0]     cnt;
   logic [BW-1:0]     bidx;
   logic [WORD_W-1:0] shreg;
   logic              slow;
   logic [CW-1:0]     half_lim, gap_lim;
   logic              gap_done;

   function automatic logic [WORD_W-1:0] with_parity(
      input logic [WORD_W-1:0] w, input logic en, input logic even);
      logic [WORD_W-1:0] r;
      r = w;
      if (en) r[WORD_W-1] = (^w[WORD_W-2:0]) ^ ~even;
      return r;
   endfunction

   assign half_lim = slow ? CW'(LS_HALF - 1) : CW'(HS_HALF - 1);
   assign gap_lim  = slow ? CW'(LS_GAP - 1)  : CW'(HS_GAP - 1);
   assign gap_done = (ph == PH_GAP) && (cnt == gap_lim);
   assign q_pop    = tx_en && !q_empty && ((ph == PH_IDLE) || gap_done);
   assign drive_a  = (ph == PH_MARK) &&  shreg[0];
   assign drive_b  = (ph == PH_MARK) && !shreg[0];
   assign idle     = (ph == PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph    <= PH_IDLE;
         cnt   <= '0;
         bidx  <= '0;
         shreg <= '0;
         slow  <= 1'b0;
      end else if (q_pop) begin
         shreg <= with_parity(q_head, par_en, par_even);
         slow  <= rate_low;
         ph    <= PH_MARK;
         cnt   <= '0;
         bidx  <= '0;
      end else begin
         unique case (ph)
            PH_MARK: begin
               if (cnt == half_lim) begin
                  ph  <= PH_SPACE;
                  cnt <= '0;
               end else cnt <= cnt + 1'b1;
            end
            PH_SPACE: begin
               if (cnt == half_lim) begin
                  cnt <= '0;
                  if (bidx == BW'(WORD_W - 1)) ph <= PH_GAP;
                  else begin
                     bidx  <= bidx + 1'b1;
                     shreg <= shreg >> 1;
                     ph    <= PH_MARK;
                  end
               end else cnt <= cnt + 1'b1;
            end
            PH_GAP: begin
               if (gap_done) ph <= PH_IDLE;
               else cnt <= cnt + 1'b1;
            end
            default: ;
         endcase
      end
   end

   // R1: the two lines are never driven high together
   p_no_both_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(drive_a && drive_b));

   // R2 / R3: a driven half ends only after the full half length
   p_mark_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((ph == PH_SPACE) && $past(ph == PH_MARK)) |-> ($past(cnt) == $past(half_lim)));

   // R4: the gap ends only after the full gap length
   p_gap_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ph == PH_GAP) && (ph != PH_GAP)) |-> ($past(cnt) == $past(gap_lim)));

   // R9: an enabled idle engine with queued data starts bit 1 on the next edge
   p_prompt_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((ph == PH_IDLE) && tx_en && !q_empty) |=> ((ph == PH_MARK) && (bidx == '0)));

endmodule

// File: rtl/a429_tx.sv
module a429_tx #(
   parameter int WORD_W  = 32,
   parameter int DEPTH   = 32,
   parameter int HS_HALF = 5,
   parameter int LS_HALF = 40,
   parameter int HS_GAP  = 40,
   parameter int LS_GAP  = 320,
   localparam int HALF_W = WORD_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [HALF_W-1:0] wr_data,
   input  logic              tx_en,
   input  logic              rate_low,
   input  logic              par_en,
   input  logic              par_even,
   input  logic              test_null,
   output logic              line_a,
   output logic              line_b,
   output logic              tx_ready
);

   if ((WORD_W % 2) != 0 || WORD_W < 4) begin : g_bad_width
      $error("a429_tx: WORD_W must be even and at least 4");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("a429_tx: DEPTH must be a power of two, at least 2");
   end
   if (HS_HALF < 1 || LS_HALF < 1 || HS_GAP < 1 || LS_GAP < 1) begin : g_bad_timing
      $error("a429_tx: all timing counts must be at least 1");
   end

   logic              commit;
   logic [WORD_W-1:0] commit_word;
   logic              q_pop, q_empty, q_full;
   logic [WORD_W-1:0] q_head;
   logic              drive_a, drive_b, eng_idle;

   a429_half_loader #(.WORD_W(WORD_W)) u_loader (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .commit(commit), .commit_word(commit_word));

   a429_word_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(commit), .push_data(commit_word),
      .pop(q_pop), .head(q_head), .empty(q_empty), .full(q_full));

   a429_bit_engine #(
      .WORD_W(WORD_W), .HS_HALF(HS_HALF), .LS_HALF(LS_HALF),
      .HS_GAP(HS_GAP), .LS_GAP(LS_GAP)) u_engine (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rate_low(rate_low),
      .par_en(par_en), .par_even(par_even), .q_empty(q_empty),
      .q_head(q_head), .q_pop(q_pop), .drive_a(drive_a),
      .drive_b(drive_b), .idle(eng_idle));

   assign line_a   = drive_a && !test_null;
   assign line_b   = drive_b && !test_null;
   assign tx_ready = q_empty && eng_idle;

   // R10: a ready transmitter keeps both lines quiet
   p_ready_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> (!line_a && !line_b));

   // R7: a full queue is never reported as ready
   p_full_not_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
      q_full |-> !tx_ready);

endmodule

// File: tb/a429_tx_tb.sv
module a429_tx_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WD_LIMIT   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic        tx_en = 1'b0, rate_low = 1'b0, par_en = 1'b1, par_even = 1'b0, test_null = 1'b0;
   logic        line_a, line_b, tx_ready;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   a429_tx dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .tx_en(tx_en), .rate_low(rate_low), .par_en(par_en),
      .par_even(par_even), .test_null(test_null),
      .line_a(line_a), .line_b(line_b), .tx_ready(tx_ready));

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, act, exp, cyc);
      end
   endtask

   function automatic logic [31:0] ref_parity(input logic [31:0] w, input bit en, input bit ev);
      int ones;
      ones = $countones(w[30:0]);
      if (en) w[31] = ev ? (ones % 2 == 1) : (ones % 2 == 0);
      return w;
   endfunction

   // ---------------- behavioural reference model ----------------
   logic [31:0] mq[$];
   int          m_ph = 0, m_cnt = 0, m_bit = 0;
   logic [31:0] m_word = '0;
   bit          m_slow = 0, m_half = 0;
   logic [15:0] m_low = '0;

   always @(posedge clk) begin : mdl
      int hl, gl;
      bit full_pre, load;
      logic [31:0] w;
      if (!rst_n) begin
         mq.delete();
         m_ph = 0; m_cnt = 0; m_bit = 0; m_half = 0; m_slow = 0; m_word = '0;
      end else begin
         hl = m_slow ? 40 : 5;
         gl = m_slow ? 320 : 40;
         full_pre = (mq.size() >= 32);
         load = tx_en && (mq.size() > 0) && (m_ph == 0 || (m_ph == 3 && m_cnt == gl - 1));
         if (load) begin
            w = mq.pop_front();
            m_word = ref_parity(w, par_en, par_even);
            m_slow = rate_low; m_ph = 1; m_cnt = 0; m_bit = 0;
         end else begin
            case (m_ph)
               1: if (m_cnt == hl - 1) begin m_ph = 2; m_cnt = 0; end else m_cnt++;
               2: if (m_cnt == hl - 1) begin
                     m_cnt = 0;
                     if (m_bit == 31) m_ph = 3;
                     else begin m_bit++; m_ph = 1; end
                  end else m_cnt++;
               3: if (m_cnt == gl - 1) m_ph = 0; else m_cnt++;
               default: ;
            endcase
         end
         if (wr_en) begin
            if (!m_half) begin m_low = wr_data; m_half = 1; end
            else begin
               m_half = 0;
               if (!full_pre) mq.push_back({wr_data, m_low});
            end
         end
      end
   end

   // per-cycle comparison against the model (R1, R2, R3, R4, R10, R11)
   always @(negedge clk) begin : cmp
      bit ea, eb, er;
      string tag;
      if (rst_n) begin
         ea = !test_null && (m_ph == 1) &&  m_word[m_bit];
         eb = !test_null && (m_ph == 1) && !m_word[m_bit];
         er = (mq.size() == 0) && (m_ph == 0);
         if (test_null) tag = "R11";
         else if (m_ph == 3) tag = "R4";
         else if (m_ph == 0) tag = "R10";
         else if (m_slow) tag = "R3";
         else tag = "R2";
         check({line_a, line_b} == {ea, eb}, tag, "lines A/B", {line_a, line_b}, {ea, eb});
         check(!(line_a && line_b), "R1", "both lines high", {line_a, line_b}, 0);
         check(tx_ready == er, "R10", "tx_ready", tx_ready, er);
      end
   end

   // ---------------- independent line decoder ----------------
   logic [31:0] rxq[$];
   logic [31:0] shbuf = '0;
   int nbits = 0, words_seen = 0, null_run = 0, hi_run = 0, last_gap = 0, last_hi = 0;
   bit prev_act = 0;

   always @(negedge clk) begin : dec
      bit act;
      if (rst_n) begin
         act = line_a || line_b;
         if (act && !prev_act) begin
            if (nbits == 0 && words_seen > 0) last_gap = null_run;
            shbuf[nbits] = line_a;
            nbits++;
            if (nbits == 32) begin
               rxq.push_back(shbuf);
               nbits = 0;
               words_seen++;
            end
            hi_run = 1;
         end else if (act) hi_run++;
         if (!act) begin
            if (prev_act) begin last_hi = hi_run; null_run = 1; end
            else null_run++;
         end
         prev_act = act;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == WD_LIMIT) begin
         n_fail++;
         $display("FAIL R10 watchdog expired: actual cycle %0d expected below %0d", cyc, WD_LIMIT);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   // ---------------- stimulus tasks ----------------
   task automatic put_half(input logic [15:0] d);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_data = d;
   endtask

   task automatic wr_off();
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic write_word(input logic [31:0] w);
      put_half(w[15:0]);
      put_half(w[31:16]);
      wr_off();
   endtask

   task automatic clear_rx();
      @(posedge clk); #1;
      rxq.delete(); nbits = 0; words_seen = 0;
   endtask

   task automatic set_en(input bit v);
      @(posedge clk); #1;
      tx_en = v;
   endtask

   task automatic wait_ready(input int maxc);
      for (int i = 0; i < maxc; i++) begin
         @(negedge clk);
         if (tx_ready) break;
      end
   endtask

   task automatic wait_cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // ---------------- scenarios ----------------
   logic [31:0] sent[$];

   initial begin
      // reset state (R10)
      wait_cycles(3);
      check(tx_ready == 1'b1, "R10", "ready in reset", tx_ready, 1);
      check({line_a, line_b} == 2'b00, "R10", "lines in reset", {line_a, line_b}, 0);
      @(posedge clk); #1; rst_n = 1'b1;
      wait_cycles(2);
      check(tx_ready == 1'b1, "R10", "ready after reset", tx_ready, 1);

      // fast rate, odd parity, three words (R2 R4 R5 R8 R9 R12)
      rate_low = 0; par_en = 1; par_even = 0;
      sent = '{32'h0000_0001, 32'hA5C3_1E77, 32'h7FFF_0002};
      foreach (sent[i]) write_word(sent[i]);
      set_en(1);
      @(negedge clk); @(negedge clk);
      check(line_a == 1'b1 && line_b == 1'b0, "R9", "first bit latency", {line_a, line_b}, 2'b10);
      wait_ready(5000);
      set_en(0);
      check(rxq.size() == 3, "R8", "fast word count", rxq.size(), 3);
      foreach (sent[i])
         if (i < rxq.size())
            check(rxq[i] == ref_parity(sent[i], 1, 0), "R12", "fast odd word", rxq[i], ref_parity(sent[i], 1, 0));
      check($countones(rxq[0]) % 2 == 1, "R5", "odd total parity", $countones(rxq[0]), 1);
      check(last_hi == 5, "R2", "fast driven half", last_hi, 5);
      check(last_gap == 45, "R4", "fast inter-word null run", last_gap, 45);
      clear_rx();

      // even parity (R5)
      par_even = 1;
      sent = '{32'h0000_0003, 32'h1234_5678};
      foreach (sent[i]) write_word(sent[i]);
      set_en(1); wait_ready(5000); set_en(0);
      check(rxq.size() == 2, "R5", "even word count", rxq.size(), 2);
      foreach (sent[i])
         if (i < rxq.size()) begin
            check(rxq[i] == ref_parity(sent[i], 1, 1), "R5", "even word", rxq[i], ref_parity(sent[i], 1, 1));
            check($countones(rxq[i]) % 2 == 0, "R5", "even total parity", $countones(rxq[i]), 0);
         end
      clear_rx();

      // parity bypass (R6)
      par_en = 0;
      sent = '{32'h8000_0001, 32'h7FFF_FFFE};
      foreach (sent[i]) write_word(sent[i]);
      set_en(1); wait_ready(5000); set_en(0);
      check(rxq.size() == 2, "R6", "bypass word count", rxq.size(), 2);
      foreach (sent[i])
         if (i < rxq.size())
            check(rxq[i] == sent[i], "R6", "bypass word unchanged", rxq[i], sent[i]);
      clear_rx();

      // slow rate (R3 R4)
      rate_low = 1; par_en = 1; par_even = 0;
      sent = '{32'h0F0F_3C3C, 32'h0000_0002};
      foreach (sent[i]) write_word(sent[i]);
      set_en(1); wait_ready(20000); set_en(0);
      check(rxq.size() == 2, "R3", "slow word count", rxq.size(), 2);
      if (rxq.size() == 2)
         check(rxq[1] == ref_parity(sent[1], 1, 0), "R3", "slow word", rxq[1], ref_parity(sent[1], 1, 0));
      check(last_hi == 40, "R3", "slow driven half", last_hi, 40);
      check(last_gap == 360, "R4", "slow inter-word null run", last_gap, 360);
      clear_rx();

      // lone half commits nothing, then queue overflow (R8 R7)
      rate_low = 0; par_en = 0;
      sent.delete();
      for (int i = 0; i < 33; i++) sent.push_back(32'h1000_0000 + i * 32'h0101_0103);
      put_half(sent[0][15:0]); wr_off();
      wait_cycles(2);
      check(tx_ready == 1'b1, "R8", "ready after lone half", tx_ready, 1);
      put_half(sent[0][31:16]); wr_off();
      wait_cycles(1);
      check(tx_ready == 1'b0, "R8", "ready after second half", tx_ready, 0);
      for (int i = 1; i < 33; i++) write_word(sent[i]);
      set_en(1); wait_ready(20000); set_en(0);
      check(rxq.size() == 32, "R7", "words kept by full queue", rxq.size(), 32);
      if (rxq.size() == 32) begin
         check(rxq[0] == sent[0], "R7", "first queued word", rxq[0], sent[0]);
         check(rxq[31] == sent[31], "R7", "last kept word", rxq[31], sent[31]);
      end
      clear_rx();

      // test null mid-word (R11)
      write_word(32'hFFFF_FFFF);
      set_en(1);
      wait_cycles(30);
      @(posedge clk); #1; test_null = 1;
      wait_cycles(2);
      check({line_a, line_b} == 2'b00, "R11", "lines under test", {line_a, line_b}, 0);
      check(tx_ready == 1'b0, "R11", "sequencing continues", tx_ready, 0);
      wait_cycles(100);
      @(posedge clk); #1; test_null = 0;
      wait_ready(5000); set_en(0);
      clear_rx();

      // enable dropped mid-word (R13)
      write_word(32'h0000_00AA);
      write_word(32'h0000_0055);
      set_en(1);
      wait_cycles(20);
      set_en(0);
      wait_cycles(600);
      check(rxq.size() == 1, "R13", "words sent after disable", rxq.size(), 1);
      check(tx_ready == 1'b0, "R13", "queue still holds a word", tx_ready, 0);
      check({line_a, line_b} == 2'b00, "R13", "lines quiet while held", {line_a, line_b}, 0);
      set_en(1); wait_ready(5000); set_en(0);
      check(rxq.size() == 2, "R13", "held word sent on re-enable", rxq.size(), 2);
      if (rxq.size() == 2)
         check(rxq[1] == 32'h0000_0055, "R13", "held word value", rxq[1], 32'h0000_0055);

      wait_cycles(5);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule